// File: doc/BRIEF.md
# Audio Sample Streaming DMA

This engine fetches a stored audio sample out of system memory one 32-byte block at a time. The host writes a 32-bit start address into two 16-bit registers. It then writes a control word whose top bit starts or stops playback and whose low fifteen bits give the sample length counted in 32-byte blocks.

While playback runs, the engine holds a block request toward a memory port. For every block that the port accepts, it moves its address forward by 32 and takes 32 off a live bytes-remaining counter, which the host can read. When the counter reaches zero, the engine pulses a done line for the interrupt logic and goes idle. Clearing the play bit in the middle of a transfer lets the block in flight finish and issues no further requests.

Top module: `sample_stream_dma`

## Requirements
- R1: After reset, memReq and done are low, and every register readback (offsets 0x30, 0x32, 0x36, 0x38, 0x3A) returns 0.
- R2: A write to offset 0x30 sets bits 31..16 of the start address and a write to 0x32 sets bits 15..0. Both read back unchanged.
- R3: Playback starts on a write to 0x36 with bit 15 set and a non-zero length in bits 14..0 while idle. From the next cycle, memReq is high, memAddr equals the start address, and the bytes-left count equals the length times 32.
- R4: Each clock edge with memReq and memAck both high accepts one block. memAddr then rises by 32 and the bytes-left count falls by 32 in the next cycle.
- R5: Once raised, memReq stays high with memAddr unchanged until memAck is seen.
- R6: When the last block is accepted, done is high for exactly one cycle and memReq is low. The bytes-left count reads 0, and bit 15 of the 0x36 readback (the playing flag) reads 0.
- R7: A write to 0x36 with bit 15 clear during playback lets the pending request complete. After that, no further request is raised, done stays low, and the bytes-left count keeps the untransferred amount.
- R8: A start with length 0 raises no request and pulses done for one cycle, in the cycle after the write.
- R9: The bytes-left count is 20 bits wide. Offset 0x3A reads bits 15..0 and offset 0x38 reads bits 19..16 in its low four bits.
- R10: While playing, a write to 0x36 with bit 15 set is ignored: the address, the count and the stored length are unchanged.
- R11: done is never high in a cycle where memReq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register offset for write and read |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Readback of the register at regAddr (combinational) |
| memReq | output | 1 | Block request toward the memory port |
| memAddr | output | 32 | Byte address of the requested block |
| memAck | input | 1 | Memory port accepts the current block |
| done | output | 1 | One-cycle completion pulse |

## Verification
A register write sampled at edge k shows its effect in the cycle that follows: memReq, memAddr and the bytes-left readback change after edge k. An accepted block moves the address and count at the edge where memAck is sampled. done is registered and is high only in the cycle after the starting write (zero length) or after the last accepting edge. The bench drives inputs on falling edges and samples every output on the falling edge that follows the edge in question. This makes the due cycle of each result exact, including the single-cycle width of done.

// File: rtl/sample_dma_pkg.sv
package sample_dma_pkg;
  localparam logic [7:0] OFS_ADDR_HI  = 8'h30;
  localparam logic [7:0] OFS_ADDR_LO  = 8'h32;
  localparam logic [7:0] OFS_CTRL     = 8'h36;
  localparam logic [7:0] OFS_LEFT_HI  = 8'h38;
  localparam logic [7:0] OFS_LEFT_LO  = 8'h3A;

  typedef enum logic {ST_IDLE, ST_ACTIVE} dmaState_t;

  typedef struct packed {
    logic lenWe;
    logic startRun;
    logic advance;
  } dmaStrobe_t;
endpackage

// File: rtl/sample_dma_ctrl.sv
module sample_dma_ctrl
  import sample_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic       ctrlPlay,
  input  logic       ctrlLenZero,
  input  logic       lastBlock,
  input  logic       memAck,
  output dmaStrobe_t strobe,
  output logic       memReq,
  output logic       done,
  output logic       active
);
  dmaState_t state;
  logic stopPending;
  logic doneQ;
  logic handshake;
  logic isIdle;
  logic stopReq;

  always_comb begin
    isIdle          = (state == ST_IDLE);
    active          = (state == ST_ACTIVE);
    memReq          = active;
    handshake       = memReq && memAck;
    stopReq         = ctrlWe && !ctrlPlay && active;
    strobe.lenWe    = ctrlWe && isIdle;
    strobe.startRun = ctrlWe && ctrlPlay && isIdle;
    strobe.advance  = handshake;
    done            = doneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      stopPending <= 1'b0;
      doneQ       <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          stopPending <= 1'b0;
          if (strobe.startRun) begin
            if (ctrlLenZero) doneQ <= 1'b1;
            else             state <= ST_ACTIVE;
          end
        end
        default: begin
          if (stopReq) stopPending <= 1'b1;
          if (handshake) begin
            if (lastBlock) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end else if (stopPending || stopReq) begin
              state <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sample_dma_path.sv
module sample_dma_path
  import sample_dma_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BLOCK_SHIFT = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  dmaStrobe_t          strobe,
  input  logic                wrAddrHi,
  input  logic                wrAddrLo,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [7:0]          rdAddr,
  input  logic                active,
  output logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] curAddr,
  output logic                lastBlock
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int LEN_W  = DATA_W - 1;
  localparam int CNT_W  = LEN_W + BLOCK_SHIFT;
  localparam logic [ADDR_W-1:0] BLK_A = ADDR_W'(1) << BLOCK_SHIFT;
  localparam logic [CNT_W-1:0]  BLK_C = CNT_W'(1) << BLOCK_SHIFT;

  logic [ADDR_W-1:0] startAddr;
  logic [LEN_W-1:0]  lenReg;
  logic [CNT_W-1:0]  bytesLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      lenReg    <= '0;
      curAddr   <= '0;
      bytesLeft <= '0;
    end else begin
      if (wrAddrHi) startAddr[ADDR_W-1:DATA_W] <= wrData;
      if (wrAddrLo) startAddr[DATA_W-1:0]      <= wrData;
      if (strobe.lenWe) lenReg <= wrData[LEN_W-1:0];
      if (strobe.startRun) begin
        curAddr   <= startAddr;
        bytesLeft <= {wrData[LEN_W-1:0], {BLOCK_SHIFT{1'b0}}};
      end else if (strobe.advance) begin
        curAddr   <= curAddr + BLK_A;
        bytesLeft <= bytesLeft - BLK_C;
      end
    end
  end

  always_comb begin
    lastBlock = (bytesLeft == BLK_C);
    case (rdAddr)
      OFS_ADDR_HI: rdData = startAddr[ADDR_W-1:DATA_W];
      OFS_ADDR_LO: rdData = startAddr[DATA_W-1:0];
      OFS_CTRL:    rdData = {active, lenReg};
      OFS_LEFT_HI: rdData = DATA_W'(bytesLeft >> DATA_W);
      OFS_LEFT_LO: rdData = bytesLeft[DATA_W-1:0];
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/sample_stream_dma.sv
module sample_stream_dma
  import sample_dma_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BLOCK_SHIFT = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [7:0]          regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                memReq,
  output logic [2*DATA_W-1:0] memAddr,
  input  logic                memAck,
  output logic                done
);
  localparam int LEN_W = DATA_W - 1;

  dmaStrobe_t strobe;
  logic active;
  logic lastBlock;
  logic ctrlWe;

  assign ctrlWe = regWrEn && (regAddr == OFS_CTRL);

  sample_dma_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlWe      (ctrlWe),
    .ctrlPlay    (regWrData[DATA_W-1]),
    .ctrlLenZero (regWrData[LEN_W-1:0] == '0),
    .lastBlock   (lastBlock),
    .memAck      (memAck),
    .strobe      (strobe),
    .memReq      (memReq),
    .done        (done),
    .active      (active)
  );

  sample_dma_path #(.DATA_W(DATA_W), .BLOCK_SHIFT(BLOCK_SHIFT)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrAddrHi  (regWrEn && (regAddr == OFS_ADDR_HI)),
    .wrAddrLo  (regWrEn && (regAddr == OFS_ADDR_LO)),
    .wrData    (regWrData),
    .rdAddr    (regAddr),
    .active    (active),
    .rdData    (regRdData),
    .curAddr   (memAddr),
    .lastBlock (lastBlock)
  );
endmodule

// File: rtl/sample_dma_chk.sv
module sample_dma_chk #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_SHIFT = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << BLOCK_SHIFT;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (memAddr == $past(memAddr) + STEP));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R6
  done_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> !done);
endmodule

bind sample_stream_dma sample_dma_chk #(.ADDR_W(2*DATA_W), .BLOCK_SHIFT(BLOCK_SHIFT)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memReq  (memReq),
  .memAck  (memAck),
  .memAddr (memAddr),
  .done    (done)
);

// File: tb/sample_stream_dma_tb.sv
module sample_stream_dma_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [15:0] regWrData = 16'h0000;
  logic [15:0] regRdData;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic        done;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sample_stream_dma u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 8'h00; regWrData = 16'h0000;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [15:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
    regAddr = 8'h00;
  endtask

  task automatic ackBlocks(input int n);
    memAck = 1'b1;
    repeat (n) @(negedge clk);
    memAck = 1'b0;
  endtask

  task automatic testReset();
    logic [15:0] d;
    check("R1 memReq", memReq, 0);
    check("R1 done", done, 0);
    foreach (d[i]) begin end
    rdReg(8'h30, d); check("R1 addrHi", d, 0);
    rdReg(8'h32, d); check("R1 addrLo", d, 0);
    rdReg(8'h36, d); check("R1 ctrl", d, 0);
    rdReg(8'h38, d); check("R1 leftHi", d, 0);
    rdReg(8'h3A, d); check("R1 leftLo", d, 0);
  endtask

  task automatic testFullRun();
    logic [15:0] d;
    wrReg(8'h30, 16'h1000);
    wrReg(8'h32, 16'h0040);
    rdReg(8'h30, d); check("R2 addrHi", d, 16'h1000);
    rdReg(8'h32, d); check("R2 addrLo", d, 16'h0040);
    check("R2 no start", memReq, 0);
    wrReg(8'h36, 16'h8003);
    check("R3 memReq", memReq, 1);
    check("R3 memAddr", memAddr, 32'h1000_0040);
    rdReg(8'h3A, d); check("R3 left", d, 16'd96);
    rdReg(8'h36, d); check("R3 ctrl readback", d, 16'h8003);
    repeat (2) @(negedge clk);
    check("R5 held", memReq, 1);
    check("R5 addr stable", memAddr, 32'h1000_0040);
    ackBlocks(1);
    check("R4 addr", memAddr, 32'h1000_0060);
    rdReg(8'h3A, d); check("R4 left", d, 16'd64);
    check("R6 no early done", done, 0);
    ackBlocks(2);
    check("R6 done", done, 1);
    check("R11 memReq low", memReq, 0);
    rdReg(8'h3A, d); check("R6 left zero", d, 0);
    rdReg(8'h36, d); check("R6 ctrl", d, 16'h0003);
    @(negedge clk);
    check("R6 done width", done, 0);
    check("R6 idle", memReq, 0);
  endtask

  task automatic testStop();
    logic [15:0] d;
    wrReg(8'h30, 16'h0000);
    wrReg(8'h32, 16'h2000);
    wrReg(8'h36, 16'h8005);
    ackBlocks(1);
    rdReg(8'h3A, d); check("R4 left stop", d, 16'd128);
    wrReg(8'h36, 16'h0005);
    check("R7 in flight", memReq, 1);
    check("R7 addr", memAddr, 32'h0000_2020);
    ackBlocks(1);
    check("R7 req dropped", memReq, 0);
    check("R7 no done", done, 0);
    repeat (3) @(negedge clk);
    check("R7 stays idle", memReq, 0);
    rdReg(8'h3A, d); check("R7 left kept", d, 16'd96);
    rdReg(8'h36, d); check("R7 ctrl", d, 16'h0005);
  endtask

  task automatic testZero();
    wrReg(8'h36, 16'h8000);
    check("R8 done", done, 1);
    check("R8 no req", memReq, 0);
    @(negedge clk);
    check("R8 done width", done, 0);
    check("R8 still no req", memReq, 0);
  endtask

  task automatic testLarge();
    logic [15:0] d;
    wrReg(8'h30, 16'h0001);
    wrReg(8'h32, 16'h0000);
    wrReg(8'h36, 16'hFFFF);
    rdReg(8'h3A, d); check("R9 leftLo", d, 16'hFFE0);
    rdReg(8'h38, d); check("R9 leftHi", d, 16'h000F);
    wrReg(8'h36, 16'h8001);
    check("R10 addr", memAddr, 32'h0001_0000);
    rdReg(8'h3A, d); check("R10 left", d, 16'hFFE0);
    rdReg(8'h36, d); check("R10 len", d, 16'hFFFF);
    wrReg(8'h36, 16'h0000);
    ackBlocks(1);
    check("R7 large stop", memReq, 0);
    rdReg(8'h3A, d); check("R9 leftLo after", d, 16'hFFC0);
    rdReg(8'h38, d); check("R9 leftHi after", d, 16'h000F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullRun();
    testStop();
    testZero();
    testLarge();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule